// File: doc/BRIEF.md
# Snoop Writeback Line Buffer

This block is a single-entry holding buffer in the bus interface. It keeps one modified cache line that must be written back because a snoop hit it. Two snoop causes load it. The first is an internal snoop made during an instruction-cache read miss that finds a modified data line. The second is an external inquire cycle, with its invalidate indication set, that finds a modified line. The entry stores the line address, all 32 bytes of data and a one-bit cause code.

The held line goes out on a bus-side port as a burst of 64-bit beats in ascending order. Each beat is handed off with an acknowledge. The entry becomes free only after the last beat has been acknowledged. A capture request that arrives while the entry is occupied is refused with a stall and does not touch the held line.

The replacement/invalidation writeback buffer is a separate structure that runs concurrently with this one. Here it appears only as a request input and a grant output. Whenever both buffers want the bus, the snoop buffer has priority.

Top module: `snoop_wb_buf`

## Requirements
- R1: After reset, full, busy, drn_valid, cap_stall and conflict are all 0.
- R2: A cap_req that arrives while the entry is empty is accepted. From the next cycle, full=1, drn_valid=1, drn_addr equals the captured address and drn_cause equals the captured cause (0 = internal snoop on an instruction-cache miss, 1 = external inquire with invalidate).
- R3: A cap_req that arrives while full=1 raises cap_stall in the same cycle. The held address, cause and data stay unchanged.
- R4: The line drains in four beats with drn_idx = 0,1,2,3. Beat k carries bits [64k+63:64k] of the captured line. drn_idx advances by one on each cycle in which drn_valid and drn_ack are both 1.
- R5: The cycle after the acknowledge of beat 3, full and drn_valid drop to 0. busy is 1 exactly while full=1 and drn_idx is not 0.
- R6: rpl_grant = rpl_req while the entry is empty. While the entry is full, rpl_grant=0 and conflict = rpl_req, because the snoop buffer owns the bus.
- R7: drn_ack while the entry is empty has no effect: the next captured line still starts at beat 0.
- R8: A capture and a replacement request in the same cycle with the entry empty are both served: rpl_grant=1 and cap_stall=0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_req | input | 1 | Capture request from snoop logic |
| cap_addr | input | 27 | Line address of the captured line |
| cap_data | input | 256 | Full line data |
| cap_cause | input | 1 | 0 internal snoop, 1 external inquire with invalidate |
| cap_stall | output | 1 | Capture refused, entry occupied |
| full | output | 1 | Entry holds a line |
| busy | output | 1 | Drain burst in progress past its first beat |
| drn_valid | output | 1 | Beat presented on the drain port |
| drn_addr | output | 27 | Address of the held line |
| drn_cause | output | 1 | Cause code of the held line |
| drn_idx | output | 2 | Index of the presented beat |
| drn_data | output | 64 | Beat data |
| drn_ack | input | 1 | Bus accepted the presented beat |
| rpl_req | input | 1 | Replacement buffer bus request |
| rpl_grant | output | 1 | Replacement buffer granted |
| conflict | output | 1 | Replacement request blocked by snoop drain |

## Verification
The bench uses the default parameters: a 27-bit line address, a 32-byte line and 64-bit beats. With these values the burst is four beats long and drn_idx passes through every value, including the wrap from 3 back to 0. Each beat carries a distinct data word, so any beat swap or slicing error is visible. Both cause codes are captured, and the refused-capture, blocked-replacement and concurrent-grant corners are each reached with the entry either full or empty, as each case requires.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic {
    CAUSE_INT = 1'b0,
    CAUSE_EXT = 1'b1
  } swb_cause_e;

  function automatic int unsigned beats_per_line(int unsigned line_bytes,
                                                 int unsigned beat_bits);
    return (line_bytes * 8) / beat_bits;
  endfunction
endpackage

// File: rtl/swb_arb.sv
module swb_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic cap_req,
  input  logic rpl_req,
  output logic accept,
  output logic cap_stall,
  output logic rpl_grant,
  output logic conflict
);
  assign accept    = cap_req & ~full;
  assign cap_stall = cap_req & full;
  assign rpl_grant = rpl_req & ~full;
  assign conflict  = rpl_req & full;

  // R6: never grant the replacement buffer while the snoop entry drives the bus
  a_r6_snoop_priority: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !rpl_grant);
  // R3: a stalled capture is never accepted
  a_r3_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stall |-> !accept);
endmodule

// File: rtl/swb_store.sv
module swb_store #(
  parameter int ADDR_W    = 27,
  parameter int LINE_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 release_ent,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [LINE_BITS-1:0] in_data,
  input  swb_pkg::swb_cause_e  in_cause,
  output logic                 valid,
  output logic [ADDR_W-1:0]    ent_addr,
  output logic [LINE_BITS-1:0] ent_data,
  output swb_pkg::swb_cause_e  ent_cause
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (accept) begin
      valid <= 1'b1;
    end else if (release_ent) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_addr  <= '0;
      ent_data  <= '0;
      ent_cause <= swb_pkg::CAUSE_INT;
    end else if (accept) begin
      ent_addr  <= in_addr;
      ent_data  <= in_data;
      ent_cause <= in_cause;
    end
  end

  // R3: while held, the line contents are not replaced
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !release_ent |=> $stable(ent_addr) && $stable(ent_data) && $stable(ent_cause));
endmodule

// File: rtl/swb_drain.sv
module swb_drain #(
  parameter int LINE_BITS = 256,
  parameter int BEAT_BITS = 64,
  localparam int BEATS = LINE_BITS / BEAT_BITS,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic [LINE_BITS-1:0] ent_data,
  input  logic                 ack,
  output logic                 beat_valid,
  output logic [IDX_W-1:0]     beat_idx,
  output logic [BEAT_BITS-1:0] beat_data,
  output logic                 last_ack,
  output logic                 busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  function automatic logic [BEAT_BITS-1:0] slice_beat(logic [LINE_BITS-1:0] line,
                                                      logic [IDX_W-1:0] k);
    return line[k*BEAT_BITS +: BEAT_BITS];
  endfunction

  logic beat_fire;

  assign beat_valid = valid;
  assign beat_fire  = valid & ack;
  assign last_ack   = beat_fire & (beat_idx == LAST);
  assign beat_data  = slice_beat(ent_data, beat_idx);
  assign busy       = valid & (beat_idx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_idx <= '0;
    end else if (last_ack) begin
      beat_idx <= '0;
    end else if (beat_fire) begin
      beat_idx <= beat_idx + 1'b1;
    end
  end

  // R4: beats advance in ascending order
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !last_ack |=> beat_idx == $past(beat_idx) + 1'b1);
  // R7: acknowledges without a held line leave the index untouched
  a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> beat_idx == '0);
  // R5: the entry empties right after the final beat is accepted
  a_r5_free_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_ack |=> !valid);
endmodule

// File: rtl/snoop_wb_buf.sv
module snoop_wb_buf #(
  parameter int ADDR_W     = 27,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BITS  = 64,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int BEATS     = swb_pkg::beats_per_line(LINE_BYTES, BEAT_BITS),
  localparam int IDX_W     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_req,
  input  logic [ADDR_W-1:0]    cap_addr,
  input  logic [LINE_BITS-1:0] cap_data,
  input  logic                 cap_cause,
  output logic                 cap_stall,
  output logic                 full,
  output logic                 busy,
  output logic                 drn_valid,
  output logic [ADDR_W-1:0]    drn_addr,
  output logic                 drn_cause,
  output logic [IDX_W-1:0]     drn_idx,
  output logic [BEAT_BITS-1:0] drn_data,
  input  logic                 drn_ack,
  input  logic                 rpl_req,
  output logic                 rpl_grant,
  output logic                 conflict
);
  logic                 accept;
  logic                 release_ent;
  logic [LINE_BITS-1:0] ent_data;
  swb_pkg::swb_cause_e  ent_cause;

  swb_arb u_arb (
    .clk(clk), .rst_n(rst_n), .full(full), .cap_req(cap_req), .rpl_req(rpl_req),
    .accept(accept), .cap_stall(cap_stall), .rpl_grant(rpl_grant), .conflict(conflict)
  );

  swb_store #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .release_ent(release_ent),
    .in_addr(cap_addr), .in_data(cap_data), .in_cause(swb_pkg::swb_cause_e'(cap_cause)),
    .valid(full), .ent_addr(drn_addr), .ent_data(ent_data), .ent_cause(ent_cause)
  );

  swb_drain #(.LINE_BITS(LINE_BITS), .BEAT_BITS(BEAT_BITS)) u_drain (
    .clk(clk), .rst_n(rst_n), .valid(full), .ent_data(ent_data), .ack(drn_ack),
    .beat_valid(drn_valid), .beat_idx(drn_idx), .beat_data(drn_data),
    .last_ack(release_ent), .busy(busy)
  );

  assign drn_cause = ent_cause;

  // R2: an accepted capture shows up as a held line on the next cycle
  a_r2_capture_lands: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> full && drn_addr == $past(cap_addr));
endmodule

// File: tb/snoop_wb_buf_tb.sv
module snoop_wb_buf_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_req = 1'b0;
  logic [26:0]  cap_addr = '0;
  logic [255:0] cap_data = '0;
  logic         cap_cause = 1'b0;
  logic         cap_stall, full, busy, drn_valid, drn_cause, rpl_grant, conflict;
  logic [26:0]  drn_addr;
  logic [1:0]   drn_idx;
  logic [63:0]  drn_data;
  logic         drn_ack = 1'b0;
  logic         rpl_req = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  snoop_wb_buf u_dut (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cap_addr(cap_addr),
    .cap_data(cap_data), .cap_cause(cap_cause), .cap_stall(cap_stall),
    .full(full), .busy(busy), .drn_valid(drn_valid), .drn_addr(drn_addr),
    .drn_cause(drn_cause), .drn_idx(drn_idx), .drn_data(drn_data),
    .drn_ack(drn_ack), .rpl_req(rpl_req), .rpl_grant(rpl_grant), .conflict(conflict)
  );

  // address[26:0], seed[31:0], cause
  localparam logic [59:0] VEC [4] = '{
    {27'h0000123, 32'hDEAD0001, 1'b0},
    {27'h7FFFFFF, 32'hCAFE0002, 1'b1},
    {27'h0000000, 32'h12345678, 1'b1},
    {27'h2AAAAAA, 32'hFFFFFFFF, 1'b0}
  };

  function automatic logic [63:0] word_of(logic [31:0] seed, int k);
    return {seed ^ 32'(k * 32'h01010101), 32'hA5A50000 | 32'(k)};
  endfunction

  function automatic logic [255:0] line_of(logic [31:0] seed);
    logic [255:0] l;
    for (int k = 0; k < 4; k++) l[k*64 +: 64] = word_of(seed, k);
    return l;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic capture(logic [26:0] a, logic [31:0] s, logic c);
    cap_req = 1'b1; cap_addr = a; cap_data = line_of(s); cap_cause = c;
    @(negedge clk);
    cap_req = 1'b0;
  endtask

  task automatic drain(logic [31:0] s, string tag);
    for (int k = 0; k < 4; k++) begin
      check({tag, " R4 idx"}, 256'(drn_idx), 256'(k));
      check({tag, " R4 data"}, 256'(drn_data), 256'(word_of(s, k)));
      check({tag, " R5 busy"}, 256'(busy), 256'(k != 0));
      drn_ack = 1'b1;
      @(negedge clk);
      drn_ack = 1'b0;
      if (k < 3) check({tag, " R5 held"}, 256'(full), 256'(1));
    end
    check({tag, " R5 freed"}, 256'(full), 256'(0));
    check({tag, " R5 valid low"}, 256'(drn_valid), 256'(0));
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 full", 256'(full), 256'(0));
    check("R1 busy", 256'(busy), 256'(0));
    check("R1 drn_valid", 256'(drn_valid), 256'(0));
    check("R1 stall", 256'(cap_stall), 256'(0));
    check("R1 conflict", 256'(conflict), 256'(0));

    // table walk: R2 capture, R4/R5 drain
    for (int i = 0; i < 4; i++) begin
      capture(VEC[i][59:33], VEC[i][32:1], VEC[i][0]);
      check("R2 full", 256'(full), 256'(1));
      check("R2 addr", 256'(drn_addr), 256'(VEC[i][59:33]));
      check("R2 cause", 256'(drn_cause), 256'(VEC[i][0]));
      drain(VEC[i][32:1], "vec");
    end

    // R3 capture while full is refused and does not overwrite
    capture(27'h0000055, 32'h0BADF00D, 1'b0);
    cap_req = 1'b1; cap_addr = 27'h1111111; cap_data = line_of(32'h99999999); cap_cause = 1'b1;
    #1;
    check("R3 stall", 256'(cap_stall), 256'(1));
    // R6 replacement blocked while full
    rpl_req = 1'b1;
    #1;
    check("R6 conflict", 256'(conflict), 256'(1));
    check("R6 no grant", 256'(rpl_grant), 256'(0));
    @(negedge clk);
    cap_req = 1'b0; rpl_req = 1'b0;
    check("R3 addr kept", 256'(drn_addr), 256'(27'h0000055));
    check("R3 cause kept", 256'(drn_cause), 256'(0));
    drain(32'h0BADF00D, "R3");

    // R7 ack while empty is ignored
    drn_ack = 1'b1;
    @(negedge clk);
    @(negedge clk);
    drn_ack = 1'b0;
    check("R7 still empty", 256'(full), 256'(0));

    // R8 concurrent capture and replacement request on an empty entry
    cap_req = 1'b1; cap_addr = 27'h0000777; cap_data = line_of(32'h00C0FFEE); cap_cause = 1'b1;
    rpl_req = 1'b1;
    #1;
    check("R8 rpl_grant", 256'(rpl_grant), 256'(1));
    check("R8 no stall", 256'(cap_stall), 256'(0));
    check("R8 no conflict", 256'(conflict), 256'(0));
    @(negedge clk);
    cap_req = 1'b0; rpl_req = 1'b0;
    check("R8 captured", 256'(full), 256'(1));
    check("R7 starts at beat 0", 256'(drn_idx), 256'(0));
    drain(32'h00C0FFEE, "R8");

    // R6 grant when empty
    rpl_req = 1'b1;
    #1;
    check("R6 grant when empty", 256'(rpl_grant), 256'(1));
    rpl_req = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule